// File: doc/BRIEF.md
# Privileged Control Register File

This block is the privileged state store of a processor core. Software-visible control registers sit behind a numbered port. The core presents a 6-bit register number together with a write strobe, a read strobe or both. The block applies a per-register write mask, keeps a five-way stack of trap-state registers selected by the current trap level, and builds a composite translation-context word when that number is read. It also drives a level interrupt that asks for service when the trap level is written to zero under the right hypervisor conditions.

Reads are registered. The value selected in one cycle appears on `rd_data` in the next cycle, and `rd_data` is zero in every other cycle. Any access that cannot be served raises `acc_illegal` for exactly one cycle and changes no state. The response side is a three-state machine. `RSP_IDLE` means no result is pending. `RSP_DATA` means a read result is on `rd_data`. `RSP_FAULT` means the previous access was refused. All three states can be reached from any state in a single cycle. The transition is to `RSP_FAULT` on an illegal access, to `RSP_DATA` on a legal read, and to `RSP_IDLE` otherwise (an idle cycle or a legal write without a read).

Register numbers are as follows:
- 0: cycle counter image (plain)
- 1: FP register status
- 2: trap base
- 3: processor state
- 4: trap level
- 5: interrupt level
- 6: hypervisor state
- 7: strand status
- 8: primary context
- 9: secondary context
- 10: partition id
- 11: load/store control
- 12: context word (read-only)
- 16 to 20: trap stack, in the order trap PC, trap next PC, trap state, trap type, hypervisor trap state
- 32 to 39: scratchpad
- 40 to 47: queue pointers

Every other number is unimplemented.

Top module: `priv_ctl_regs`

## Requirements
- R1: A write to the trap base (number 2) stores the data with bits 14:0 cleared.
- R2: A write to the processor state (number 3) keeps only bits 1 (interrupt enable), 2 (privileged), 3 (address mask), 4 (FP enable), 7:6 (memory model), 8 (trap little-endian), 9 (current little-endian) and 11 (pid1), which is mask 0xBDE. All other bits read back as 0.
- R3: A write to the trap level sets `tlz_irq` when hypervisor-state bit 0 (tlz) is 1, hypervisor-state bit 2 (hpriv) is 0 and the new level is 0. Any other trap-level write clears it. The new value is visible in the cycle after the write.
- R4: Numbers 16 to 20 address five independent arrays with MAX_TL entries each. Reads and writes use entry TL-1.
- R5: A trap-stack access while TL is 0 or greater than MAX_TL is illegal and writes nothing.
- R6: After reset the following values hold, and every other register reads 0:
  - number 0 reads 0x8000_0000_0000_0000
  - number 6 reads 0x800 (bit 11 set)
  - number 7 reads 0x50000
- R7: A read of number 1 returns the stored value with bits 1:0 forced to 1.
- R8: Number 12 reads a packed word, and a write to it is illegal. The fields are:
  - bit 0: hypervisor-state bit 2
  - bit 1: hypervisor-state bit 5
  - bit 2: processor-state bit 2
  - bit 3: processor-state bit 3
  - bits 5:4: load/store control bits 3:2
  - bits 15:8: partition id bits 7:0
  - bits 18:16: TL bits 2:0
  - bits 47:32: primary context bits 15:0
  - bits 63:48: secondary context bits 15:0
- R9: Numbers 32 to 47 are plain full-width read/write registers.
- R10: An access to an unimplemented number sets `acc_illegal` in the next cycle for one cycle, keeps `rd_data` at 0 and changes no state.
- R11: A trap-level write keeps only the low TL_W = clog2(MAX_TL+1) bits of the data.
- R12: Read data appears in the cycle after a legal read and is 0 otherwise. A read and a write in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 6 | Register number |
| wr_data | input | 64 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 64 | Read result, one cycle after the read |
| acc_illegal | output | 1 | One-cycle refusal flag |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |

## Verification
A wrong trap level shows up in several places: the TL field of the context word, a trap-stack read that returns the entry of a different level, and an access refused at a level that should be valid. Each of these appears in the cycle after the read that exposes it. A mask or reset error in a stored register appears on the first read of that number. A wrong interrupt decision shows on `tlz_irq` in the cycle right after the trap-level write. An access wrongly judged illegal, or wrongly accepted, shows one cycle later on `acc_illegal`. A trap-stack write that was wrongly accepted is also seen later as changed data at that level.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
    localparam int SEL_W      = 6;
    localparam int NUM_SEL    = 1 << SEL_W;
    localparam int DATA_W     = 64;
    localparam int TRAP_KINDS = 5;

    localparam logic [SEL_W-1:0] S_TICK   = 6'd0;
    localparam logic [SEL_W-1:0] S_FPRS   = 6'd1;
    localparam logic [SEL_W-1:0] S_TBASE  = 6'd2;
    localparam logic [SEL_W-1:0] S_PSTATE = 6'd3;
    localparam logic [SEL_W-1:0] S_TL     = 6'd4;
    localparam logic [SEL_W-1:0] S_HPST   = 6'd6;
    localparam logic [SEL_W-1:0] S_STRAND = 6'd7;
    localparam logic [SEL_W-1:0] S_PCTX   = 6'd8;
    localparam logic [SEL_W-1:0] S_SCTX   = 6'd9;
    localparam logic [SEL_W-1:0] S_PART   = 6'd10;
    localparam logic [SEL_W-1:0] S_LSU    = 6'd11;
    localparam logic [SEL_W-1:0] S_CTXW   = 6'd12;
    localparam logic [SEL_W-1:0] S_TRAP0  = 6'd16;
    localparam logic [SEL_W-1:0] S_SPAD0  = 6'd32;
    localparam logic [SEL_W-1:0] S_LAST   = 6'd47;

    localparam logic [DATA_W-1:0] PSTATE_KEEP = 64'h0000_0000_0000_0BDE;
    localparam logic [DATA_W-1:0] TBASE_KEEP  = ~64'h7FFF;

    typedef enum logic [2:0] {
        CLS_NONE, CLS_STORE, CLS_TL, CLS_CTX, CLS_TRAP
    } sel_class_e;

    typedef enum logic [1:0] {
        RSP_IDLE, RSP_DATA, RSP_FAULT
    } rsp_state_e;

    function automatic bit is_stored(input logic [SEL_W-1:0] s);
        return (s <= S_LSU && s != S_TL) || (s >= S_SPAD0 && s <= S_LAST);
    endfunction

    function automatic logic [DATA_W-1:0] keep_mask(input logic [SEL_W-1:0] s);
        if (s == S_TBASE)  return TBASE_KEEP;
        if (s == S_PSTATE) return PSTATE_KEEP;
        return '1;
    endfunction

    function automatic logic [DATA_W-1:0] reset_val(input logic [SEL_W-1:0] s);
        if (s == S_TICK)   return 64'h8000_0000_0000_0000;
        if (s == S_HPST)   return 64'h800;
        if (s == S_STRAND) return 64'h5_0000;
        return '0;
    endfunction
endpackage

// File: rtl/pcr_cell.sv
module pcr_cell #(
    parameter int              W    = 64,
    parameter logic [W-1:0]    RST  = '0,
    parameter logic [W-1:0]    KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= d & KEEP;
    end
endmodule

// File: rtl/pcr_decode.sv
module pcr_decode
    import pcr_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int TL_W   = 3
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [TL_W-1:0]  tl,
    input  logic             wr_en,
    output sel_class_e       cls,
    output logic [2:0]       trap_kind,
    output logic             legal
);
    always_comb begin
        cls       = CLS_NONE;
        trap_kind = '0;
        if (is_stored(sel))            cls = CLS_STORE;
        else if (sel == S_TL)          cls = CLS_TL;
        else if (sel == S_CTXW)        cls = CLS_CTX;
        else if (sel >= S_TRAP0 && int'(sel) < int'(S_TRAP0) + TRAP_KINDS) begin
            cls       = CLS_TRAP;
            trap_kind = 3'(sel - S_TRAP0);
        end
    end

    always_comb begin
        legal = 1'b1;
        if (cls == CLS_NONE)                                  legal = 1'b0;
        if (cls == CLS_CTX && wr_en)                          legal = 1'b0;
        if (cls == CLS_TRAP && (tl == '0 || int'(tl) > MAX_TL)) legal = 1'b0;
    end
endmodule

// File: rtl/pcr_trapstack.sv
module pcr_trapstack
    import pcr_pkg::*;
#(
    parameter int MAX_TL = 6,
    parameter int TL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [2:0]        kind,
    input  logic [TL_W-1:0]   slot,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [TRAP_KINDS][MAX_TL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < TRAP_KINDS; k++)
                for (int e = 0; e < MAX_TL; e++)
                    mem_q[k][e] <= '0;
        end else if (we && int'(kind) < TRAP_KINDS && int'(slot) < MAX_TL) begin
            mem_q[kind][slot] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (int'(kind) < TRAP_KINDS && int'(slot) < MAX_TL)
            rdata = mem_q[kind][slot];
    end

    // R4: a write only ever lands inside the stack
    assert_slot_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> (int'(slot) < MAX_TL && int'(kind) < TRAP_KINDS));
endmodule

// File: rtl/priv_ctl_regs.sv
module priv_ctl_regs
    import pcr_pkg::*;
#(
    parameter int MAX_TL = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              acc_illegal,
    output logic              tlz_irq
);
    localparam int TL_W = $clog2(MAX_TL + 1);

    sel_class_e        cls;
    logic [2:0]        trap_kind;
    logic              legal;
    logic [TL_W-1:0]   tl_q;
    logic              irq_q;
    logic [DATA_W-1:0] cell_q [NUM_SEL];
    logic [DATA_W-1:0] trap_rd;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] ctx_word;
    logic              do_wr;
    logic              access;
    rsp_state_e        state_q, state_d;

    assign access = wr_en | rd_en;
    assign do_wr  = wr_en & legal;

    pcr_decode #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_decode (
        .sel(reg_sel), .tl(tl_q), .wr_en(wr_en),
        .cls(cls), .trap_kind(trap_kind), .legal(legal)
    );

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_reg
        if (is_stored(SEL_W'(g))) begin : g_cell
            pcr_cell #(
                .W(DATA_W),
                .RST(reset_val(SEL_W'(g))),
                .KEEP(keep_mask(SEL_W'(g)))
            ) u_cell (
                .clk(clk), .rst_n(rst_n),
                .we(do_wr && cls == CLS_STORE && reg_sel == SEL_W'(g)),
                .d(wr_data), .q(cell_q[g])
            );
        end else begin : g_none
            assign cell_q[g] = '0;
        end
    end

    pcr_trapstack #(.MAX_TL(MAX_TL), .TL_W(TL_W)) u_trap (
        .clk(clk), .rst_n(rst_n),
        .we(do_wr && cls == CLS_TRAP),
        .kind(trap_kind), .slot(tl_q - TL_W'(1)),
        .wdata(wr_data), .rdata(trap_rd)
    );

    // trap level and its interrupt, decided against the current hypervisor state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tl_q  <= '0;
            irq_q <= 1'b0;
        end else if (do_wr && cls == CLS_TL) begin
            tl_q  <= wr_data[TL_W-1:0];
            irq_q <= cell_q[S_HPST][0] && !cell_q[S_HPST][2] && wr_data[TL_W-1:0] == '0;
        end
    end

    logic [DATA_W-1:0] tl_wide;
    assign tl_wide = DATA_W'(tl_q);

    always_comb begin
        ctx_word        = '0;
        ctx_word[0]     = cell_q[S_HPST][2];
        ctx_word[1]     = cell_q[S_HPST][5];
        ctx_word[2]     = cell_q[S_PSTATE][2];
        ctx_word[3]     = cell_q[S_PSTATE][3];
        ctx_word[5:4]   = cell_q[S_LSU][3:2];
        ctx_word[15:8]  = cell_q[S_PART][7:0];
        ctx_word[18:16] = tl_wide[2:0];
        ctx_word[47:32] = cell_q[S_PCTX][15:0];
        ctx_word[63:48] = cell_q[S_SCTX][15:0];
    end

    always_comb begin
        unique case (cls)
            CLS_STORE: rd_mux = cell_q[reg_sel] | ((reg_sel == S_FPRS) ? 64'h3 : 64'h0);
            CLS_TL:    rd_mux = tl_wide;
            CLS_CTX:   rd_mux = ctx_word;
            CLS_TRAP:  rd_mux = trap_rd;
            default:   rd_mux = '0;
        endcase
    end

    // response state machine: state register
    always_comb begin
        if (access && !legal) state_d = RSP_FAULT;
        else if (rd_en)       state_d = RSP_DATA;
        else                  state_d = RSP_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en && legal) rdata_q <= rd_mux;
        end
    end

    // response state machine: outputs
    always_comb begin
        rd_data     = '0;
        acc_illegal = 1'b0;
        unique case (state_q)
            RSP_DATA:  rd_data     = rdata_q;
            RSP_FAULT: acc_illegal = 1'b1;
            default:   ;
        endcase
    end

    assign tlz_irq = irq_q;

    assert_tbase_low_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cell_q[S_TBASE][14:0] == '0);

    assert_pstate_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_q[S_PSTATE] & ~PSTATE_KEEP) == '0);

    assert_irq_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == S_TL && cell_q[S_HPST][0] && !cell_q[S_HPST][2]
         && wr_data[TL_W-1:0] == '0) |=> tlz_irq);

    assert_irq_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_sel == S_TL && (!cell_q[S_HPST][0] || cell_q[S_HPST][2]
         || wr_data[TL_W-1:0] != '0)) |=> !tlz_irq);

    assert_illegal_keeps_tl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !legal) |=> $stable(tl_q));

    assert_fprs_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_sel == S_FPRS) |=> rd_data[1:0] == 2'b11);

    assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (access && !legal) |=> (acc_illegal && rd_data == '0));

    assert_fault_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !access |=> !acc_illegal);
endmodule

// File: tb/priv_ctl_regs_tb.sv
module priv_ctl_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_sel = '0;
    logic [63:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [63:0] rd_data;
    logic        acc_illegal;
    logic        tlz_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit cur_irq = 0;

    typedef struct {
        logic [63:0] rd;
        bit          ill;
        bit          irq;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    priv_ctl_regs #(.MAX_TL(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .acc_illegal(acc_illegal), .tlz_irq(tlz_irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [5:0] s, input logic [63:0] d, input bit we, input bit re,
                       input logic [63:0] exp_rd, input bit exp_ill, input string tag);
        exp_t e;
        @(negedge clk);
        reg_sel = s; wr_data = d; wr_en = we; rd_en = re;
        e.rd = exp_rd; e.ill = exp_ill; e.irq = cur_irq; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [5:0] s, input logic [63:0] d, input string tag);
        acc(s, d, 1'b1, 1'b0, 64'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [5:0] s, input logic [63:0] exp, input string tag);
        acc(s, 64'h0, 1'b0, 1'b1, exp, 1'b0, tag);
    endtask

    task automatic bad(input logic [5:0] s, input bit we, input bit re, input string tag);
        acc(s, 64'hDEAD_BEEF_0BAD_F00D, we, re, 64'h0, 1'b1, tag);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (rd_data !== e.rd || acc_illegal !== e.ill || tlz_irq !== e.irq) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h ill=%0d irq=%0d expected rd_data=%h ill=%0d irq=%0d",
                             e.tag, rd_data, acc_illegal, tlz_irq, e.rd, e.ill, e.irq);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_data == 64'h0, "R6 reset rd_data", rd_data, 64'h0);
        chk(acc_illegal == 1'b0, "R6 reset illegal", 64'(acc_illegal), 64'h0);
        chk(tlz_irq == 1'b0, "R6 reset irq", 64'(tlz_irq), 64'h0);
        rst_n = 1'b1;

        // R6 reset values
        rd(6'd0, 64'h8000_0000_0000_0000, "R6 tick reset");
        rd(6'd6, 64'h800, "R6 hypervisor state reset");
        rd(6'd7, 64'h5_0000, "R6 strand status reset");
        rd(6'd3, 64'h0, "R6 processor state reset");
        rd(6'd4, 64'h0, "R6 trap level reset");
        rd(6'd33, 64'h0, "R6 scratchpad reset");

        // R1 / R2 masks
        wr(6'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R1 trap base write");
        rd(6'd2, 64'hFFFF_FFFF_FFFF_8000, "R1 trap base low bits");
        wr(6'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R2 processor state write");
        rd(6'd3, 64'h0BDE, "R2 processor state mask");

        // R7 FP status
        wr(6'd1, 64'h4, "R7 fprs write");
        rd(6'd1, 64'h7, "R7 fprs forced bits");
        wr(6'd1, 64'h0, "R7 fprs clear");
        rd(6'd1, 64'h3, "R7 fprs zero store");

        // R5 trap stack at TL 0
        bad(6'd16, 1'b0, 1'b1, "R5 trap read at TL0");
        bad(6'd16, 1'b1, 1'b0, "R5 trap write at TL0");
        wr(6'd4, 64'h1, "R4 set TL 1");
        rd(6'd16, 64'h0, "R5 TL0 write left no data");

        // R4 indexing by TL-1
        wr(6'd16, 64'h111, "R4 tpc at TL1");
        wr(6'd19, 64'h0A1, "R4 tt at TL1");
        wr(6'd4, 64'h2, "R4 set TL 2");
        wr(6'd16, 64'h222, "R4 tpc at TL2");
        rd(6'd16, 64'h222, "R4 tpc read TL2");
        rd(6'd19, 64'h0, "R4 tt at TL2 separate");
        wr(6'd4, 64'h1, "R4 back to TL1");
        rd(6'd16, 64'h111, "R4 tpc read TL1");
        rd(6'd19, 64'h0A1, "R4 tt read TL1");
        wr(6'd20, 64'h5A5A, "R4 htstate at TL1");
        rd(6'd20, 64'h5A5A, "R4 htstate read TL1");

        // R3 interrupt
        wr(6'd6, 64'h801, "R3 set tlz");
        cur_irq = 1;
        wr(6'd4, 64'h0, "R3 TL zero raises irq");
        cur_irq = 0;
        wr(6'd4, 64'h1, "R3 TL nonzero clears irq");
        wr(6'd6, 64'h805, "R3 set tlz and hpriv");
        wr(6'd4, 64'h0, "R3 hpriv blocks irq");

        // R8 context word
        wr(6'd8, 64'h1234, "R8 primary ctx");
        wr(6'd9, 64'hABCD, "R8 secondary ctx");
        wr(6'd10, 64'h1A5, "R8 partition id");
        wr(6'd11, 64'hC, "R8 lsu control");
        wr(6'd6, 64'h24, "R8 hypervisor state");
        wr(6'd3, 64'hC, "R8 processor state");
        wr(6'd4, 64'h5, "R8 TL 5");
        rd(6'd12, 64'hABCD_1234_0005_A53F, "R8 context word");
        bad(6'd12, 1'b1, 1'b0, "R8 write to context word");

        // R11 truncation and R5 above max
        wr(6'd4, 64'h1F, "R11 TL write wide");
        rd(6'd4, 64'h7, "R11 TL truncated");
        bad(6'd17, 1'b0, 1'b1, "R5 trap read above max TL");

        // R9 scratchpad and queue pointers
        for (int i = 0; i < 16; i++)
            wr(6'(32 + i), {16'hC0DE, 8'(i), 40'(i * 3 + 1)}, "R9 plain write");
        for (int i = 0; i < 16; i++)
            rd(6'(32 + i), {16'hC0DE, 8'(i), 40'(i * 3 + 1)}, "R9 plain read");

        // R10 unimplemented numbers
        bad(6'd63, 1'b0, 1'b1, "R10 read unimplemented");
        bad(6'd13, 1'b1, 1'b1, "R10 write unimplemented");
        rd(6'd4, 64'h7, "R10 state unchanged");

        // R12 read during write returns old value
        acc(6'd5, 64'h9, 1'b1, 1'b1, 64'h0, 1'b0, "R12 read with write");
        rd(6'd5, 64'h9, "R12 new value after");

        repeat (3) @(negedge clk);
        chk(rd_data == 64'h0 && acc_illegal == 1'b0, "R12 idle output zero", rd_data, 64'h0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule